// File: doc/BRIEF.md
# Field-Chained Plane Descriptor Walker

This block is the control front end of a single graphics display plane. Software builds a chain of 16-word descriptor nodes in memory and writes the address of the first one into a queued-pointer register. On every vertical sync the block reads the queued node one word at a time through a simple read port. When the last word arrives, it presents the node's contents as the plane's live configuration to a downstream pixel fetch stage. It then takes the node's own link word as the new queued pointer. A top-field node and a bottom-field node that link to each other therefore alternate field by field with no further bus traffic.

The live configuration registers change in a single cycle, and only after all 16 words have been read, so the downstream stage never sees a mix of two nodes. The block also reports the address of the live node, the field parity captured at the vsync that loaded it, whether a fetch is in flight, and two sticky error flags. One flag marks a vsync that arrived during a fetch. The other marks a misaligned queued pointer.

Top module: `plane_desc_walker`

## Requirements
- R1: After a synchronous reset every output is zero: plane off, no fetch in flight, both flags clear, queued pointer zero.
- R2: A write on the pointer port replaces the queued pointer, and `ptr_rd_data` returns the written value from the next cycle on.
- R3: A vsync with a nonzero, 16-byte-aligned queued pointer starts a fetch of 16 words at byte addresses pointer+0, +4, ... +60, issued in order, one request at a time, each request a single-cycle pulse.
- R4: `fetch_busy` is high from the cycle after the vsync until the cycle in which the configuration changes, and while it is high no configuration output changes. All configuration outputs, `live_node_addr` and `live_field_bottom` update together on the edge where `fetch_busy` falls.
- R5: On that commit the queued pointer takes the node's word 9 (link), so two nodes that link to each other alternate on successive vsyncs.
- R6: Decoding of the committed node: `ctrl_word` is word 0 and `fmt_code` its bits 4:0; `alpha_gain` is word 1; word 3 gives `org_line` (31:16) and `org_pix` (15:0); word 4 gives `end_line` and `end_pix` the same way, inclusive; `live_pix_addr` is word 5; `line_pitch` is word 6; word 7 gives `src_height` (26:16) and `src_width` (10:0); `key_lo`, `key_hi`, `props_word` and `clut_addr` are words 10, 11, 13 and 15.
- R7: A node whose word 13 has bits 1:0 both set commits with `plane_on` low, but its link word is still taken and its address is reported as live.
- R8: A vsync with a queued pointer of zero starts no fetch and drives `plane_on` low and `live_node_addr` to zero.
- R9: A vsync with a queued pointer whose bits 3:0 are not all zero starts no fetch, sets the sticky `ptr_fault_flag` and turns the plane off.
- R10: A vsync while `fetch_busy` is high sets the sticky `overrun_flag`, starts no second fetch, and leaves the in-flight fetch to complete normally.
- R11: `field_bottom` is captured at the vsync that starts a fetch and appears on `live_field_bottom` at the commit of that node.
- R12: A pointer write made while a fetch is in flight is kept: the commit of that fetch does not overwrite it with the link word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_wr_en | input | 1 | Write strobe for the queued pointer |
| ptr_wr_data | input | 32 | Value written to the queued pointer |
| ptr_rd_data | output | 32 | Queued pointer readback |
| live_pix_addr | output | 32 | Pixel memory address of the live node |
| mem_rd_req | output | 1 | Single-cycle word read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| vsync | input | 1 | Vertical sync pulse |
| field_bottom | input | 1 | Field parity, high for bottom field |
| plane_on | output | 1 | Plane produces valid pixels |
| fmt_code | output | 5 | Pixel format code |
| ctrl_word | output | 32 | Full control word |
| alpha_gain | output | 32 | Alpha gain word |
| org_line | output | 16 | First display line |
| org_pix | output | 16 | First display pixel |
| end_line | output | 16 | Last display line, inclusive |
| end_pix | output | 16 | Last display pixel, inclusive |
| line_pitch | output | 32 | Source line pitch in bytes |
| src_width | output | 11 | Source width |
| src_height | output | 11 | Source height |
| key_lo | output | 32 | Colour key low word |
| key_hi | output | 32 | Colour key high word |
| props_word | output | 32 | Plane properties word |
| clut_addr | output | 32 | Colour lookup table address |
| live_node_addr | output | 32 | Address of the live node, zero when none |
| live_field_bottom | output | 1 | Field parity captured for the live node |
| fetch_busy | output | 1 | Node fetch in flight |
| overrun_flag | output | 1 | Sticky: vsync arrived during a fetch |
| ptr_fault_flag | output | 1 | Sticky: misaligned queued pointer at vsync |

## Verification
The assertions check the properties that hold on every cycle. There is never more than one read request in flight. Request addresses are word aligned. The configuration stays frozen while a fetch is in flight. A vsync during a fetch always raises the overrun flag, and both error flags stay set. A lit plane always points at a nonzero, aligned node. Other behaviour can only be shown by the directed scenarios. These cover the exact order and addresses of the 16 reads, the field decoding of each word, top and bottom nodes alternating through their links, and an ignored node continuing the walk. They also cover a pointer write racing a fetch, and vsyncs seen with a zero or a misaligned pointer.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int NODE_WORDS = 16;
  localparam int NODE_ALIGN = 16;
  // word positions inside a node; the walker decodes these
  localparam int W_CTRL  = 0;
  localparam int W_GAIN  = 1;
  localparam int W_ORG   = 3;
  localparam int W_END   = 4;
  localparam int W_PIX   = 5;
  localparam int W_PITCH = 6;
  localparam int W_SIZE  = 7;
  localparam int W_LINK  = 9;
  localparam int W_KEYLO = 10;
  localparam int W_KEYHI = 11;
  localparam int W_PROP  = 13;
  localparam int W_CLUT  = 15;

  typedef enum logic [2:0] {
    VS_NONE,
    VS_FETCH,
    VS_OFF,
    VS_FAULT,
    VS_DROP
  } vs_action_t;
endpackage

// File: rtl/pdw_node_fetch.sv
module pdw_node_fetch #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int NODE_WORDS = pdw_pkg::NODE_WORDS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [AW-1:0]            base_addr,
  output logic                     mem_rd_req,
  output logic [AW-1:0]            mem_rd_addr,
  input  logic                     mem_rd_valid,
  input  logic [DW-1:0]            mem_rd_data,
  output logic                     busy,
  output logic                     done,
  output logic [NODE_WORDS*DW-1:0] words
);
  localparam int IDX_W = $clog2(NODE_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [IDX_W-1:0] idx;
  logic             cap;

  assign cap = busy && mem_rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      idx         <= '0;
    end else begin
      done       <= 1'b0;
      mem_rd_req <= 1'b0;
      if (!busy && !done && start) begin
        busy        <= 1'b1;
        idx         <= '0;
        mem_rd_req  <= 1'b1;
        mem_rd_addr <= base_addr;
      end else if (cap) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx         <= idx + 1'b1;
          mem_rd_req  <= 1'b1;
          mem_rd_addr <= mem_rd_addr + STEP;
        end
      end
    end
  end

  // one shadow register per node word, written as its response arrives
  for (genvar g = 0; g < NODE_WORDS; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)
        words[g*DW +: DW] <= '0;
      else if (cap && idx == IDX_W'(g))
        words[g*DW +: DW] <= mem_rd_data;
    end
  end

  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);
  assert_word_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));
endmodule

// File: rtl/pdw_list_ctrl.sv
module pdw_list_ctrl #(
  parameter int AW         = 32,
  parameter int NODE_ALIGN = pdw_pkg::NODE_ALIGN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vsync,
  input  logic          field_bottom,
  input  logic          ptr_wr_en,
  input  logic [AW-1:0] ptr_wr_data,
  input  logic          busy,
  input  logic          commit,
  input  logic [AW-1:0] link_word,
  output logic          start,
  output logic [AW-1:0] start_addr,
  output logic          go_off,
  output logic [AW-1:0] queued_ptr,
  output logic [AW-1:0] pend_addr,
  output logic          pend_field,
  output logic          overrun_flag,
  output logic          fault_flag
);
  import pdw_pkg::*;
  localparam int ALIGN_BITS = $clog2(NODE_ALIGN);

  vs_action_t act;
  logic       sw_hold;

  always_comb begin
    if (!vsync)                               act = VS_NONE;
    else if (busy)                            act = VS_DROP;
    else if (queued_ptr == '0)                act = VS_OFF;
    else if (queued_ptr[ALIGN_BITS-1:0] != '0) act = VS_FAULT;
    else                                      act = VS_FETCH;
  end

  assign start      = (act == VS_FETCH);
  assign go_off     = (act == VS_OFF) || (act == VS_FAULT);
  assign start_addr = queued_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      queued_ptr   <= '0;
      pend_addr    <= '0;
      pend_field   <= 1'b0;
      overrun_flag <= 1'b0;
      fault_flag   <= 1'b0;
      sw_hold      <= 1'b0;
    end else begin
      if (ptr_wr_en)
        queued_ptr <= ptr_wr_data;
      else if (commit && !sw_hold)
        queued_ptr <= link_word;

      if (commit)
        sw_hold <= 1'b0;
      else if (ptr_wr_en && busy)
        sw_hold <= 1'b1;

      if (start) begin
        pend_addr  <= queued_ptr;
        pend_field <= field_bottom;
      end
      if (act == VS_DROP)  overrun_flag <= 1'b1;
      if (act == VS_FAULT) fault_flag   <= 1'b1;
    end
  end

  assert_overrun_on_busy_vsync_R10: assert property (@(posedge clk) disable iff (rst)
    (vsync && busy) |=> overrun_flag);
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overrun_flag |=> overrun_flag);
  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    fault_flag |=> fault_flag);
  assert_no_start_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/pdw_cfg_bank.sv
module pdw_cfg_bank #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int NODE_WORDS = pdw_pkg::NODE_WORDS,
  parameter int SIZE_W     = 11,
  parameter int COORD_W    = 16,
  parameter int FMT_W      = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit,
  input  logic                     go_off,
  input  logic [NODE_WORDS*DW-1:0] words,
  input  logic [AW-1:0]            pend_addr,
  input  logic                     pend_field,
  output logic                     plane_on,
  output logic [FMT_W-1:0]         fmt_code,
  output logic [DW-1:0]            ctrl_word,
  output logic [DW-1:0]            alpha_gain,
  output logic [COORD_W-1:0]       org_line,
  output logic [COORD_W-1:0]       org_pix,
  output logic [COORD_W-1:0]       end_line,
  output logic [COORD_W-1:0]       end_pix,
  output logic [AW-1:0]            live_pix_addr,
  output logic [DW-1:0]            line_pitch,
  output logic [SIZE_W-1:0]        src_width,
  output logic [SIZE_W-1:0]        src_height,
  output logic [DW-1:0]            key_lo,
  output logic [DW-1:0]            key_hi,
  output logic [DW-1:0]            props_word,
  output logic [AW-1:0]            clut_addr,
  output logic [AW-1:0]            live_node_addr,
  output logic                     live_field_bottom
);
  import pdw_pkg::*;
  localparam int HALF = DW / 2;

  logic [DW-1:0] w_ctrl, w_org, w_end, w_size, w_prop;
  logic          ignore;

  assign w_ctrl = words[W_CTRL*DW +: DW];
  assign w_org  = words[W_ORG*DW  +: DW];
  assign w_end  = words[W_END*DW  +: DW];
  assign w_size = words[W_SIZE*DW +: DW];
  assign w_prop = words[W_PROP*DW +: DW];
  assign ignore = &w_prop[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      plane_on          <= 1'b0;
      fmt_code          <= '0;
      ctrl_word         <= '0;
      alpha_gain        <= '0;
      org_line          <= '0;
      org_pix           <= '0;
      end_line          <= '0;
      end_pix           <= '0;
      live_pix_addr     <= '0;
      line_pitch        <= '0;
      src_width         <= '0;
      src_height        <= '0;
      key_lo            <= '0;
      key_hi            <= '0;
      props_word        <= '0;
      clut_addr         <= '0;
      live_node_addr    <= '0;
      live_field_bottom <= 1'b0;
    end else if (commit) begin
      plane_on          <= !ignore;
      fmt_code          <= w_ctrl[FMT_W-1:0];
      ctrl_word         <= w_ctrl;
      alpha_gain        <= words[W_GAIN*DW +: DW];
      org_line          <= w_org[HALF +: COORD_W];
      org_pix           <= w_org[COORD_W-1:0];
      end_line          <= w_end[HALF +: COORD_W];
      end_pix           <= w_end[COORD_W-1:0];
      live_pix_addr     <= words[W_PIX*DW +: AW];
      line_pitch        <= words[W_PITCH*DW +: DW];
      src_width         <= w_size[SIZE_W-1:0];
      src_height        <= w_size[HALF +: SIZE_W];
      key_lo            <= words[W_KEYLO*DW +: DW];
      key_hi            <= words[W_KEYHI*DW +: DW];
      props_word        <= w_prop;
      clut_addr         <= words[W_CLUT*DW +: AW];
      live_node_addr    <= pend_addr;
      live_field_bottom <= pend_field;
    end else if (go_off) begin
      plane_on       <= 1'b0;
      live_node_addr <= '0;
    end
  end

  assert_lit_needs_node_R8: assert property (@(posedge clk) disable iff (rst)
    plane_on |-> (live_node_addr != '0) && (live_node_addr[3:0] == 4'h0));
  assert_commit_not_off_R4: assert property (@(posedge clk) disable iff (rst)
    !(commit && go_off));
endmodule

// File: rtl/plane_desc_walker.sv
module plane_desc_walker #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int SIZE_W  = 11,
  parameter int COORD_W = 16,
  parameter int FMT_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ptr_wr_en,
  input  logic [AW-1:0]      ptr_wr_data,
  output logic [AW-1:0]      ptr_rd_data,
  output logic [AW-1:0]      live_pix_addr,
  output logic               mem_rd_req,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [DW-1:0]      mem_rd_data,
  input  logic               vsync,
  input  logic               field_bottom,
  output logic               plane_on,
  output logic [FMT_W-1:0]   fmt_code,
  output logic [DW-1:0]      ctrl_word,
  output logic [DW-1:0]      alpha_gain,
  output logic [COORD_W-1:0] org_line,
  output logic [COORD_W-1:0] org_pix,
  output logic [COORD_W-1:0] end_line,
  output logic [COORD_W-1:0] end_pix,
  output logic [DW-1:0]      line_pitch,
  output logic [SIZE_W-1:0]  src_width,
  output logic [SIZE_W-1:0]  src_height,
  output logic [DW-1:0]      key_lo,
  output logic [DW-1:0]      key_hi,
  output logic [DW-1:0]      props_word,
  output logic [AW-1:0]      clut_addr,
  output logic [AW-1:0]      live_node_addr,
  output logic               live_field_bottom,
  output logic               fetch_busy,
  output logic               overrun_flag,
  output logic               ptr_fault_flag
);
  import pdw_pkg::*;
  localparam int NW = NODE_WORDS;

  logic             f_busy, f_done, start, go_off, pend_field;
  logic [AW-1:0]    start_addr, pend_addr;
  logic [NW*DW-1:0] words;

  assign fetch_busy = f_busy | f_done;

  pdw_list_ctrl #(.AW(AW), .NODE_ALIGN(NODE_ALIGN)) u_ctrl (
    .clk(clk), .rst(rst), .vsync(vsync), .field_bottom(field_bottom),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data), .busy(fetch_busy),
    .commit(f_done), .link_word(words[W_LINK*DW +: AW]),
    .start(start), .start_addr(start_addr), .go_off(go_off),
    .queued_ptr(ptr_rd_data), .pend_addr(pend_addr), .pend_field(pend_field),
    .overrun_flag(overrun_flag), .fault_flag(ptr_fault_flag)
  );

  pdw_node_fetch #(.AW(AW), .DW(DW), .NODE_WORDS(NW)) u_fetch (
    .clk(clk), .rst(rst), .start(start), .base_addr(start_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .busy(f_busy), .done(f_done), .words(words)
  );

  pdw_cfg_bank #(.AW(AW), .DW(DW), .NODE_WORDS(NW), .SIZE_W(SIZE_W),
                 .COORD_W(COORD_W), .FMT_W(FMT_W)) u_bank (
    .clk(clk), .rst(rst), .commit(f_done), .go_off(go_off), .words(words),
    .pend_addr(pend_addr), .pend_field(pend_field),
    .plane_on(plane_on), .fmt_code(fmt_code), .ctrl_word(ctrl_word),
    .alpha_gain(alpha_gain), .org_line(org_line), .org_pix(org_pix),
    .end_line(end_line), .end_pix(end_pix), .live_pix_addr(live_pix_addr),
    .line_pitch(line_pitch), .src_width(src_width), .src_height(src_height),
    .key_lo(key_lo), .key_hi(key_hi), .props_word(props_word),
    .clut_addr(clut_addr), .live_node_addr(live_node_addr),
    .live_field_bottom(live_field_bottom)
  );

  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_busy && $past(fetch_busy)) |-> ($stable(live_pix_addr) &&
      $stable(live_node_addr) && $stable(ctrl_word) && $stable(plane_on)));
  assert_busy_quiet_port_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> fetch_busy);
endmodule

// File: tb/plane_desc_walker_tb.sv
module plane_desc_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_wr_en = 1'b0;
  logic [31:0] ptr_wr_data = '0;
  logic [31:0] ptr_rd_data, live_pix_addr, mem_rd_addr;
  logic        mem_rd_req;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        vsync = 1'b0, field_bottom = 1'b0;
  logic        plane_on, live_field_bottom, fetch_busy, overrun_flag, ptr_fault_flag;
  logic [4:0]  fmt_code;
  logic [31:0] ctrl_word, alpha_gain, line_pitch, key_lo, key_hi, props_word, clut_addr, live_node_addr;
  logic [15:0] org_line, org_pix, end_line, end_pix;
  logic [10:0] src_width, src_height;

  int total = 0, bad = 0;
  int req_cnt = 0;
  logic [31:0] req_log [0:255];
  logic [31:0] mem [0:63];

  always #4 clk = ~clk;

  plane_desc_walker dut_i (
    .clk(clk), .rst(rst), .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .ptr_rd_data(ptr_rd_data), .live_pix_addr(live_pix_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .vsync(vsync), .field_bottom(field_bottom), .plane_on(plane_on),
    .fmt_code(fmt_code), .ctrl_word(ctrl_word), .alpha_gain(alpha_gain),
    .org_line(org_line), .org_pix(org_pix), .end_line(end_line), .end_pix(end_pix),
    .line_pitch(line_pitch), .src_width(src_width), .src_height(src_height),
    .key_lo(key_lo), .key_hi(key_hi), .props_word(props_word), .clut_addr(clut_addr),
    .live_node_addr(live_node_addr), .live_field_bottom(live_field_bottom),
    .fetch_busy(fetch_busy), .overrun_flag(overrun_flag), .ptr_fault_flag(ptr_fault_flag)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_req;
    mem_rd_data  <= mem[mem_rd_addr[7:2]];
    if (mem_rd_req) begin
      req_log[req_cnt[7:0]] <= mem_rd_addr;
      req_cnt <= req_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_node(input int base, input logic [31:0] ctrl, pix, size, link, prop);
    int i = base >> 2;
    mem[i+0]  = ctrl;
    mem[i+1]  = 32'h0080_8080 + base;
    mem[i+2]  = 32'h0;
    mem[i+3]  = 32'h0010_0020 + base;
    mem[i+4]  = 32'h01DF_02CF;
    mem[i+5]  = pix;
    mem[i+6]  = 32'h1400 + base;
    mem[i+7]  = size;
    mem[i+8]  = 32'h0;
    mem[i+9]  = link;
    mem[i+10] = 32'hA000_0000 | base;
    mem[i+11] = 32'hB000_0000 | base;
    mem[i+12] = 32'h0;
    mem[i+13] = prop;
    mem[i+14] = 32'h0;
    mem[i+15] = 32'hC000_0000 | base;
  endtask

  task automatic write_ptr(input logic [31:0] v);
    @(negedge clk); ptr_wr_en = 1'b1; ptr_wr_data = v;
    @(negedge clk); ptr_wr_en = 1'b0;
  endtask

  task automatic pulse_vsync(input logic bot);
    @(negedge clk); vsync = 1'b1; field_bottom = bot;
    @(negedge clk); vsync = 1'b0;
  endtask

  // waits for the fetch to end; counts changes of the live config seen while busy
  task automatic wait_idle(output int changes);
    logic [31:0] snap_pix = live_pix_addr;
    logic [31:0] snap_node = live_node_addr;
    changes = 0;
    for (int n = 0; n < 300 && fetch_busy; n++) begin
      if (live_pix_addr !== snap_pix || live_node_addr !== snap_node) changes++;
      @(negedge clk);
    end
  endtask

  task automatic check_node(input string tag, input int base, input logic [31:0] ctrl, pix, size, link, prop, input logic bot);
    chk({tag, " R6 ctrl"}, ctrl_word, ctrl);
    chk({tag, " R6 fmt"}, 32'(fmt_code), 32'(ctrl[4:0]));
    chk({tag, " R6 gain"}, alpha_gain, 32'h0080_8080 + base);
    chk({tag, " R6 org_line"}, 32'(org_line), 32'h10);
    chk({tag, " R6 org_pix"}, 32'(org_pix), 32'h20 + base);
    chk({tag, " R6 end_line"}, 32'(end_line), 32'h1DF);
    chk({tag, " R6 end_pix"}, 32'(end_pix), 32'h2CF);
    chk({tag, " R6 pix"}, live_pix_addr, pix);
    chk({tag, " R6 pitch"}, line_pitch, 32'h1400 + base);
    chk({tag, " R6 width"}, 32'(src_width), 32'(size[10:0]));
    chk({tag, " R6 height"}, 32'(src_height), 32'(size[26:16]));
    chk({tag, " R6 keys"}, key_lo ^ key_hi, (32'hA000_0000 | base) ^ (32'hB000_0000 | base));
    chk({tag, " R6 props"}, props_word, prop);
    chk({tag, " R6 clut"}, clut_addr, 32'hC000_0000 | base);
    chk({tag, " R5 link"}, ptr_rd_data, link);
    chk({tag, " R11 node"}, live_node_addr, base);
    chk({tag, " R11 field"}, 32'(live_field_bottom), 32'(bot));
  endtask

  localparam logic [31:0] TOP_CTRL = 32'h8000_0005, BOT_CTRL = 32'h8000_0012, IGN_CTRL = 32'h0000_000B;
  localparam logic [31:0] TOP_SIZE = 32'hF923_F2AB, BOT_SIZE = 32'h07FF_07FF;

  task automatic t_reset;
    chk("R1 plane_on", 32'(plane_on), 0);
    chk("R1 busy", 32'(fetch_busy), 0);
    chk("R1 flags", 32'({overrun_flag, ptr_fault_flag}), 0);
    chk("R1 ptr", ptr_rd_data, 0);
    chk("R1 node", live_node_addr, 0);
    chk("R1 req", 32'(mem_rd_req), 0);
  endtask

  task automatic t_write;
    write_ptr(32'h40);
    chk("R2 readback", ptr_rd_data, 32'h40);
    chk("R2 plane still off", 32'(plane_on), 0);
  endtask

  task automatic t_top_fetch;
    int c0 = req_cnt, ch, ok;
    pulse_vsync(1'b0);
    chk("R4 busy after vsync", 32'(fetch_busy), 1);
    wait_idle(ch);
    chk("R4 no change while busy", 32'(ch), 0);
    chk("R3 request count", 32'(req_cnt - c0), 16);
    ok = 1;
    for (int k = 0; k < 16; k++) if (req_log[8'(c0 + k)] !== 32'(32'h40 + 4*k)) ok = 0;
    chk("R3 request addresses in order", 32'(ok), 1);
    chk("R4 plane on", 32'(plane_on), 1);
    check_node("top", 32'h40, TOP_CTRL, 32'h1000_0000, TOP_SIZE, 32'h80, 0, 1'b0);
  endtask

  task automatic t_bot_fetch;
    int ch;
    pulse_vsync(1'b1);
    wait_idle(ch);
    check_node("bottom", 32'h80, BOT_CTRL, 32'h1000_1400, BOT_SIZE, 32'h40, 0, 1'b1);
    chk("R4 bottom plane on", 32'(plane_on), 1);
  endtask

  task automatic t_ignore;
    int ch;
    write_ptr(32'hC0);
    pulse_vsync(1'b0);
    wait_idle(ch);
    chk("R7 ignored plane off", 32'(plane_on), 0);
    chk("R7 ignored node live", live_node_addr, 32'hC0);
    chk("R7 walk continues", ptr_rd_data, 32'h40);
    pulse_vsync(1'b0);
    wait_idle(ch);
    chk("R7 next node lit", 32'(plane_on), 1);
    chk("R5 next node addr", live_node_addr, 32'h40);
  endtask

  task automatic t_sw_race;
    int ch;
    pulse_vsync(1'b1);
    write_ptr(32'hC0);
    chk("R12 still busy at write", 32'(fetch_busy), 1);
    wait_idle(ch);
    chk("R12 write kept", ptr_rd_data, 32'hC0);
    chk("R12 node loaded", live_node_addr, 32'h80);
    chk("R10 no overrun yet", 32'(overrun_flag), 0);
  endtask

  task automatic t_overrun;
    int c0, ch;
    write_ptr(32'h40);
    c0 = req_cnt;
    pulse_vsync(1'b0);
    repeat (3) @(negedge clk);
    pulse_vsync(1'b1);
    wait_idle(ch);
    repeat (4) @(negedge clk);
    chk("R10 overrun set", 32'(overrun_flag), 1);
    chk("R10 single fetch", 32'(req_cnt - c0), 16);
    chk("R10 first fetch committed", live_node_addr, 32'h40);
    chk("R10 field of first vsync", 32'(live_field_bottom), 0);
    chk("R10 no second fetch", 32'(fetch_busy), 0);
  endtask

  task automatic t_zero;
    int c0;
    write_ptr(32'h0);
    c0 = req_cnt;
    pulse_vsync(1'b0);
    repeat (3) @(negedge clk);
    chk("R8 no fetch", 32'(req_cnt - c0), 0);
    chk("R8 plane off", 32'(plane_on), 0);
    chk("R8 node zero", live_node_addr, 0);
  endtask

  task automatic t_fault;
    int c0, ch;
    write_ptr(32'h40);
    pulse_vsync(1'b0);
    wait_idle(ch);
    chk("R9 lit before fault", 32'(plane_on), 1);
    write_ptr(32'h48);
    c0 = req_cnt;
    pulse_vsync(1'b0);
    repeat (3) @(negedge clk);
    chk("R9 fault set", 32'(ptr_fault_flag), 1);
    chk("R9 no fetch", 32'(req_cnt - c0), 0);
    chk("R9 plane off", 32'(plane_on), 0);
    repeat (3) @(negedge clk);
    chk("R9 fault sticky", 32'(ptr_fault_flag), 1);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = '0;
    put_node(32'h40, TOP_CTRL, 32'h1000_0000, TOP_SIZE, 32'h80, 32'h0);
    put_node(32'h80, BOT_CTRL, 32'h1000_1400, BOT_SIZE, 32'h40, 32'h0);
    put_node(32'hC0, IGN_CTRL, 32'h2000_0000, 32'h0001_0001, 32'h40, 32'h3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_top_fetch();
    t_bot_fetch();
    t_ignore();
    t_sw_race();
    t_overrun();
    t_zero();
    t_fault();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule